// File: doc/BRIEF.md
# Oscillator Alarm Guard

This block supervises a bank of up to 32 free-running oscillators. Each oscillator delivers one sample bit per clock. The block watches every sample for runs of repeated values. A run longer than a programmable threshold counts as an alarm. The first alarm on an oscillator only marks it with a strike. A second alarm on a struck oscillator turns the oscillator off, records it in a stop register and raises a one-cycle overflow event for the bank.

Software controls the bank through a simple write port and a combinational read port. Through these ports it can:
- set the threshold;
- turn oscillators on and off;
- mask oscillators whose alarms must be ignored;
- clear stop and strike state selectively;
- drive a per-oscillator detune line.

A usual recovery sequence is to read the stop register, write that value to the detune register, clear the stop register and then write all ones to the enable register. The restarted oscillators then run at a changed frequency.

Top module: `osc_guard`

## Requirements
- R1: After reset, every enable bit is 1, the threshold is 255, and the stop, strike, mask and detune registers are 0. shut_ovf is 0.
- R2: An oscillator raises an alarm on the clock edge where its sample has equalled its previous-cycle value on thr+1 consecutive edges. Any mismatch, or an alarm, restarts the run count at zero. A run of H equal edges therefore gives floor(H/(thr+1)) alarms.
- R3: The first alarm on an oscillator sets its strike bit (read code 5) and leaves its enable and stop bits unchanged.
- R4: An alarm on an oscillator whose strike bit is set clears its enable bit and sets its stop bit in the same edge. The strike bit stays set.
- R5: shut_ovf is high for exactly the one cycle after any edge that stops at least one oscillator. Oscillators stopped on the same edge give a single pulse.
- R6: An oscillator whose mask bit is 1 never gains a strike or a stop bit.
- R7: An oscillator whose enable bit is 0 raises no alarms.
- R8: Writing code 2 clears, in both the stop and strike registers, every bit whose data bit is 0. Writing 0 clears all of them. A shutdown on the same edge still sets its bits. Clearing does not re-enable an oscillator.
- R9: Writing code 1 loads the enable register, so all ones re-enables the whole bank. A shutdown on the same edge overrides the written 1 for that oscillator.
- R10: Writing code 4 loads the detune register, which drives osc_detune. The register holds its value when no such write occurs.
- R11: Register codes for wr_sel and rd_sel are:
  - 0: threshold; only data bits 7:0 are kept.
  - 1: enable.
  - 2: stop.
  - 3: mask.
  - 4: detune.
  - 5: strike; readable only.

  Reads of codes 6 and 7 return 0. Reads return zero-extended values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_sample | input | N_OSC | One sample bit per oscillator per cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register code for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register code for the read |
| rd_data | output | 32 | Combinational read data |
| osc_en | output | N_OSC | Per-oscillator run enable |
| osc_detune | output | N_OSC | Per-oscillator detune control |
| stop_mask | output | N_OSC | Oscillators stopped by the two-strike policy |
| shut_ovf | output | 1 | One-cycle pulse when oscillators are stopped |

## Verification
Strike, stop and enable changes appear right after the edge that sees the (thr+1)-th consecutive match. shut_ovf follows one cycle later and then falls. Register writes take effect on the next edge, and rd_data follows rd_sel with no delay.

The bench drives inputs and samples outputs on falling edges. It lets a frozen run end and then toggles for several more cycles before it reads any result. It counts shut_ovf pulses over the whole run window, so a pulse cannot be missed or counted twice.

// File: rtl/osc_guard.sv
module osc_guard #(
  parameter int N_OSC = 32,
  parameter int TH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OSC-1:0] osc_sample,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [2:0]       rd_sel,
  output logic [31:0]      rd_data,
  output logic [N_OSC-1:0] osc_en,
  output logic [N_OSC-1:0] osc_detune,
  output logic [N_OSC-1:0] stop_mask,
  output logic             shut_ovf
);
  localparam logic [2:0] SEL_THR = 3'd0;
  localparam logic [2:0] SEL_EN  = 3'd1;
  localparam logic [2:0] SEL_STP = 3'd2;
  localparam logic [2:0] SEL_MSK = 3'd3;
  localparam logic [2:0] SEL_DET = 3'd4;
  localparam logic [2:0] SEL_STR = 3'd5;

  logic [TH_W-1:0]  thr_q;
  logic [N_OSC-1:0] en_q, stop_q, strike_q, mask_q, detune_q, prev_q;
  logic [N_OSC-1:0] hit, shut, keep;
  logic             ovf_q;

  wire wr_thr = wr_en && (wr_sel == SEL_THR);
  wire wr_ena = wr_en && (wr_sel == SEL_EN);
  wire wr_stp = wr_en && (wr_sel == SEL_STP);
  wire wr_msk = wr_en && (wr_sel == SEL_MSK);
  wire wr_det = wr_en && (wr_sel == SEL_DET);

  assign shut = hit & strike_q;
  assign keep = wr_stp ? wr_data[N_OSC-1:0] : {N_OSC{1'b1}};

  for (genvar i = 0; i < N_OSC; i++) begin : g_osc
    logic [TH_W-1:0] run_q;
    wire same = (osc_sample[i] == prev_q[i]);
    wire full = (run_q == thr_q);
    assign hit[i] = en_q[i] & ~mask_q[i] & same & full;
    always_ff @(posedge clk) begin
      if (!rst_n || !en_q[i] || !same || full) run_q <= '0;
      else                                     run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q    <= '1;
      en_q     <= '1;
      stop_q   <= '0;
      strike_q <= '0;
      mask_q   <= '0;
      detune_q <= '0;
      prev_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      prev_q   <= osc_sample;
      stop_q   <= (stop_q & keep) | shut;
      strike_q <= (strike_q & keep) | hit;
      en_q     <= (wr_ena ? wr_data[N_OSC-1:0] : en_q) & ~shut;
      ovf_q    <= |shut;
      if (wr_thr) thr_q    <= wr_data[TH_W-1:0];
      if (wr_msk) mask_q   <= wr_data[N_OSC-1:0];
      if (wr_det) detune_q <= wr_data[N_OSC-1:0];
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_THR: rd_data = 32'(thr_q);
      SEL_EN:  rd_data = 32'(en_q);
      SEL_STP: rd_data = 32'(stop_q);
      SEL_MSK: rd_data = 32'(mask_q);
      SEL_DET: rd_data = 32'(detune_q);
      SEL_STR: rd_data = 32'(strike_q);
      default: rd_data = '0;
    endcase
  end

  assign osc_en     = en_q;
  assign osc_detune = detune_q;
  assign stop_mask  = stop_q;
  assign shut_ovf   = ovf_q;
endmodule

// File: rtl/osc_guard_chk.sv
module osc_guard_chk #(
  parameter int N_OSC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OSC-1:0] stop,
  input logic [N_OSC-1:0] strike,
  input logic [N_OSC-1:0] mask,
  input logic [N_OSC-1:0] en,
  input logic [N_OSC-1:0] detune,
  input logic             ovf,
  input logic             wr_en,
  input logic [2:0]       wr_sel
);
  a_r5_ovf_has_new_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (|(stop & ~$past(stop))));

  a_r4_stop_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stop & ~$past(stop) & en) == '0));

  a_r4_stop_needs_strike: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stop & ~$past(stop) & ~$past(strike)) == '0));

  a_r6_masked_never_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stop & ~$past(stop) & $past(mask)) == '0));

  a_r10_detune_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !($past(wr_en) && $past(wr_sel) == 3'd4)) |-> $stable(detune));
endmodule

bind osc_guard osc_guard_chk #(.N_OSC(N_OSC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .stop   (stop_q),
  .strike (strike_q),
  .mask   (mask_q),
  .en     (en_q),
  .detune (detune_q),
  .ovf    (shut_ovf),
  .wr_en  (wr_en),
  .wr_sel (wr_sel)
);

// File: tb/tb_osc_guard.sv
`timescale 1ns/1ps
module tb_osc_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sample = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data, osc_en, osc_detune, stop_mask;
  logic        shut_ovf;
  int          n_chk = 0, n_fail = 0, ovf_cnt = 0;
  logic [31:0] v;

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;
  // threshold, run length, expected stop bit, expected strike bit
  localparam int VEC[10][4] = '{
    '{0, 1, 0, 1}, '{0, 2, 1, 1}, '{3, 3, 0, 0}, '{3, 4, 0, 1},
    '{3, 7, 0, 1}, '{3, 8, 1, 1}, '{255, 255, 0, 0}, '{255, 256, 0, 1},
    '{5, 12, 1, 1}, '{5, 11, 0, 1}};

  always #2 clk = ~clk;

  osc_guard dut (
    .clk(clk), .rst_n(rst_n), .osc_sample(sample), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .osc_en(osc_en), .osc_detune(osc_detune), .stop_mask(stop_mask),
    .shut_ovf(shut_ovf));

  always @(negedge clk) if (rst_n && shut_ovf) ovf_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [31:0] t);
    @(negedge clk);
    sample = sample ^ t;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    sample = sample ^ ALL;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    sample = sample ^ ALL;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    rd_sel = s;
    #1 d = rd_data;
  endtask

  task automatic freeze(input logic [31:0] m, input int h);
    for (int k = 0; k < 3; k++) tick(ALL);
    @(negedge clk);
    ovf_cnt = 0;
    sample = sample ^ ALL;
    for (int k = 0; k < h; k++) tick(~m);
    for (int k = 0; k < 4; k++) tick(ALL);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(ALL);
    // R1 reset state
    rd(3'd0, v); chk("R1 threshold", v, 32'd255);
    rd(3'd1, v); chk("R1 enable", v, ALL);
    rd(3'd2, v); chk("R1 stop", v, 32'd0);
    rd(3'd3, v); chk("R1 mask", v, 32'd0);
    rd(3'd4, v); chk("R1 detune", v, 32'd0);
    rd(3'd5, v); chk("R1 strike", v, 32'd0);
    chk("R1 shut_ovf", {31'd0, shut_ovf}, 32'd0);
    rd(3'd7, v); chk("R11 unused code", v, 32'd0);

    // R2 R3 R4 R5 table of run lengths on oscillator 0
    for (int r = 0; r < 10; r++) begin
      wr(3'd2, 32'd0);
      wr(3'd1, ALL);
      wr(3'd0, 32'(VEC[r][0]));
      freeze(32'h1, VEC[r][1]);
      chk($sformatf("R4 row%0d stop", r), {31'd0, stop_mask[0]}, 32'(VEC[r][2]));
      chk($sformatf("R4 row%0d enable", r), {31'd0, osc_en[0]}, 32'(1 - VEC[r][2]));
      rd(3'd5, v);
      chk($sformatf("R3 row%0d strike", r), v, 32'(VEC[r][3]));
      chk($sformatf("R5 row%0d ovf pulses", r), 32'(ovf_cnt), 32'(VEC[r][2]));
    end

    // R6 masked oscillator
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'h2);
    freeze(32'h2, 10);
    chk("R6 stop", stop_mask, 32'd0);
    rd(3'd5, v); chk("R6 strike", v, 32'd0);
    chk("R6 ovf", 32'(ovf_cnt), 32'd0);
    wr(3'd3, 32'd0);

    // R5 two oscillators stopped on the same edge
    wr(3'd0, 32'd1);
    freeze(32'hC, 4);
    chk("R5 both stopped", stop_mask, 32'hC);
    chk("R5 single pulse", 32'(ovf_cnt), 32'd1);
    chk("R4 both disabled", osc_en, ALL & ~32'hC);

    // R8 selective clear
    wr(3'd2, 32'h4);
    chk("R8 partial stop", stop_mask, 32'h4);
    rd(3'd5, v); chk("R8 partial strike", v, 32'h4);
    wr(3'd2, 32'd0);
    chk("R8 all stop", stop_mask, 32'd0);
    rd(3'd5, v); chk("R8 all strike", v, 32'd0);
    chk("R8 no re-enable", osc_en & 32'hC, 32'd0);

    // R7 disabled oscillator raises nothing
    freeze(32'h8, 10);
    rd(3'd5, v); chk("R7 strike", v, 32'd0);
    chk("R7 ovf", 32'(ovf_cnt), 32'd0);

    // R9 enable writes
    wr(3'd1, 32'hFFFF_0000);
    chk("R9 partial enable", osc_en, 32'hFFFF_0000);
    wr(3'd1, ALL);
    chk("R9 all enable", osc_en, ALL);

    // R10 detune
    wr(3'd4, 32'hA5A5_0F0F);
    chk("R10 detune out", osc_detune, 32'hA5A5_0F0F);
    freeze(32'h1, 3);
    rd(3'd4, v); chk("R10 detune held", v, 32'hA5A5_0F0F);

    // R11 threshold width
    wr(3'd0, 32'h0000_1234);
    rd(3'd0, v); chk("R11 threshold bits", v, 32'h34);

    finish_up();
  end
endmodule